// File: doc/BRIEF.md
# Debug Bus Trigger Controller

This block turns two comparator match signals, A and B, into trace-capture control for an external trace FIFO. A small control register selects one of nine ways of combining the matches, whether the trigger marks the start or the end of the captured trace, and whether a match must be confirmed by the opcode-tracking logic before it counts. The comparators, the FIFO array and the opcode pipeline sit outside. The block sees their results as plain inputs.

Software programs the register while the block is disarmed, then raises `arm`. While armed, the block watches the match inputs and the bus address. It raises a one-cycle trigger pulse once per run and drives a FIFO store enable. A capture-done flag is raised for end traces, and a per-event store strobe is raised in the event modes. All outputs are registered, so each appears one clock after the inputs that cause it.

Top module: `dbg_trig_ctrl`

## Requirements
- R1: The control register reads back with bit 7 = tag select, bit 6 = begin select, bits 5:4 always 0, and bits 3:0 = trigger mode. It resets to 0x00.
- R2: A register write while `arm` is 1 is ignored. A write while `arm` is 0 updates the register at the next clock.
- R3: Mode 0 triggers on A. Mode 1 triggers on A or B. Mode 5 triggers on A and B in the same qualified cycle. Mode 6 triggers on A without B. `trig_pulse` rises one clock after the qualifying input.
- R4: Mode 2 triggers on a B match in a cycle after an A match in the same run. A and B in the same first cycle does not trigger.
- R5: Mode 7 triggers on a valid access with bound_lo ≤ addr ≤ bound_hi. Mode 8 triggers on a valid access with addr < bound_lo or addr > bound_hi. Modes 9 to 15 never trigger.
- R6: With tag select 1, each match is held pending until `op_exec` and then counts. `op_flush` discards it. With tag select 0, matches count at once.
- R7: End trace (begin select 0, non-event modes): `fifo_store` is 1 from the clock after arming through the trigger cycle and 0 afterwards. `cap_done` rises with the trigger and stays high until disarm.
- R8: Begin trace (begin select 1, non-event modes): `fifo_store` is 0 before the trigger and 1 from the trigger on. `cap_done` stays 0.
- R9: In mode 3 (every B) and mode 4 (every B after an A), each qualifying B event pulses `evt_store` and `fifo_store`, and the first one also pulses `trig_pulse`. The begin select bit has no effect in these modes, and `cap_done` stays 0.
- R10: `trig_pulse` fires at most once per run. Lowering `arm` clears the sequence, trigger, pending and capture-done state, and all outputs go to 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| arm | input | 1 | Run enable |
| match_a | input | 1 | Comparator A match |
| match_b | input | 1 | Comparator B match |
| acc_valid | input | 1 | Bus access valid (range modes) |
| acc_addr | input | AW | Bus access address |
| bound_lo | input | AW | Range lower bound (comparator A value) |
| bound_hi | input | AW | Range upper bound (comparator B value) |
| op_exec | input | 1 | Pending opcode executed |
| op_flush | input | 1 | Pending opcode flushed |
| trig_pulse | output | 1 | One-cycle trigger indication |
| fifo_store | output | 1 | FIFO store enable |
| cap_done | output | 1 | End-trace capture finished |
| evt_store | output | 1 | Event-mode store strobe |

## Verification
The hardest situations to reach are those that depend on history within a run. Examples are an A match seen some cycles before B, a tagged match that waits for an execute or is flushed, and a second qualifying match after the trigger has already fired. The bench reaches them with directed sequences that disarm, reprogram, rearm and then drive matches in separate cycles. It also drives the same-cycle and flush-versus-execute cases that a single-cycle vector table cannot express.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'hCF;

  localparam logic [3:0] MD_A        = 4'd0;
  localparam logic [3:0] MD_A_OR_B   = 4'd1;
  localparam logic [3:0] MD_A_THEN_B = 4'd2;
  localparam logic [3:0] MD_EVT_B    = 4'd3;
  localparam logic [3:0] MD_A_EVT_B  = 4'd4;
  localparam logic [3:0] MD_A_AND_B  = 4'd5;
  localparam logic [3:0] MD_A_NOT_B  = 4'd6;
  localparam logic [3:0] MD_IN_RNG   = 4'd7;
  localparam logic [3:0] MD_OUT_RNG  = 4'd8;

  localparam int NCH  = 3;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int CH_R = 2;

  typedef struct packed {
    logic       tag_sel;
    logic       begin_sel;
    logic [1:0] rsvd;
    logic [3:0] mode;
  } trig_cfg_t;
endpackage

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg
  import dbg_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output trig_cfg_t        cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (we && !arm) cfg_q <= trig_cfg_t'(wdata & CFG_MASK);
  end
endmodule

// File: rtl/dbg_trig_qual.sv
module dbg_trig_qual
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          tag_sel,
  input  logic [3:0]    mode,
  input  logic          match_a,
  input  logic          match_b,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] bound_lo,
  input  logic [AW-1:0] bound_hi,
  input  logic          op_exec,
  input  logic          op_flush,
  output logic [NCH-1:0] qual
);
  logic below, above, rng_hit;
  logic [NCH-1:0] raw;

  assign below = acc_addr < bound_lo;
  assign above = acc_addr > bound_hi;

  always_comb begin
    rng_hit = 1'b0;
    if (acc_valid) begin
      if (mode == MD_IN_RNG)  rng_hit = !below && !above;
      if (mode == MD_OUT_RNG) rng_hit = below || above;
    end
  end

  assign raw[CH_A] = match_a;
  assign raw[CH_B] = match_b;
  assign raw[CH_R] = rng_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic pend_q;
    always_ff @(posedge clk) begin
      if (rst || !arm || !tag_sel) pend_q <= 1'b0;
      else if (op_exec || op_flush) pend_q <= raw[i];
      else if (raw[i]) pend_q <= 1'b1;
    end
    assign qual[i] = tag_sel ? (op_exec && !op_flush && pend_q) : raw[i];
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic [3:0]     mode,
  input  logic           begin_sel,
  input  logic [NCH-1:0] qual,
  output logic           trig_pulse,
  output logic           fifo_store,
  output logic           cap_done,
  output logic           evt_store
);
  logic qa, qb, qr;
  logic seq_q, trg_q;
  logic is_evt, seq_use, hit, ev, fire, trg_d, seq_d, store_d, done_d;

  assign qa = qual[CH_A];
  assign qb = qual[CH_B];
  assign qr = qual[CH_R];

  assign is_evt  = (mode == MD_EVT_B) || (mode == MD_A_EVT_B);
  assign seq_use = (mode == MD_A_THEN_B) || (mode == MD_A_EVT_B);

  always_comb begin
    hit = 1'b0;
    ev  = 1'b0;
    case (mode)
      MD_A:        hit = qa;
      MD_A_OR_B:   hit = qa || qb;
      MD_A_THEN_B: hit = seq_q && qb;
      MD_EVT_B:    ev  = qb;
      MD_A_EVT_B:  ev  = seq_q && qb;
      MD_A_AND_B:  hit = qa && qb;
      MD_A_NOT_B:  hit = qa && !qb;
      MD_IN_RNG,
      MD_OUT_RNG:  hit = qr;
      default:     hit = 1'b0;
    endcase
  end

  assign fire  = arm && !trg_q && (is_evt ? ev : hit);
  assign trg_d = arm && (trg_q || fire);
  assign seq_d = arm && (seq_q || (seq_use && qa));

  always_comb begin
    if (is_evt)         store_d = arm && ev;
    else if (begin_sel) store_d = trg_d;
    else                store_d = arm && !trg_q;
    done_d = !is_evt && !begin_sel && trg_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q      <= 1'b0;
      trg_q      <= 1'b0;
      trig_pulse <= 1'b0;
      fifo_store <= 1'b0;
      cap_done   <= 1'b0;
      evt_store  <= 1'b0;
    end else begin
      seq_q      <= seq_d;
      trg_q      <= trg_d;
      trig_pulse <= fire;
      fifo_store <= store_d;
      cap_done   <= done_d;
      evt_store  <= is_evt && arm && ev;
    end
  end
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          arm,
  input  logic          match_a,
  input  logic          match_b,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] bound_lo,
  input  logic [AW-1:0] bound_hi,
  input  logic          op_exec,
  input  logic          op_flush,
  output logic          trig_pulse,
  output logic          fifo_store,
  output logic          cap_done,
  output logic          evt_store
);
  trig_cfg_t      cfg_q;
  logic [NCH-1:0] qual;

  dbg_trig_cfg u_cfg (
    .clk(clk), .rst(rst), .arm(arm), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  dbg_trig_qual #(.AW(AW)) u_qual (
    .clk(clk), .rst(rst), .arm(arm), .tag_sel(cfg_q.tag_sel), .mode(cfg_q.mode),
    .match_a(match_a), .match_b(match_b), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .bound_lo(bound_lo), .bound_hi(bound_hi), .op_exec(op_exec), .op_flush(op_flush),
    .qual(qual)
  );

  dbg_trig_seq u_seq (
    .clk(clk), .rst(rst), .arm(arm), .mode(cfg_q.mode), .begin_sel(cfg_q.begin_sel),
    .qual(qual), .trig_pulse(trig_pulse), .fifo_store(fifo_store),
    .cap_done(cap_done), .evt_store(evt_store)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic       arm,
  input logic       trig_pulse,
  input logic       fifo_store,
  input logic       cap_done,
  input logic       evt_store
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[5:4] == 2'b00); // R1

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (arm && cfg_we) |=> $stable(cfg_rdata)); // R2

  AST_NO_TRIG_RSVD: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[3:0] > 4'd8) |=> (!trig_pulse && !evt_store)); // R5

  AST_DONE_STOPS_STORE: assert property (@(posedge clk) disable iff (rst)
    (cap_done && $past(cap_done)) |-> !fifo_store); // R7

  AST_EVT_IMPLIES_STORE: assert property (@(posedge clk) disable iff (rst)
    evt_store |-> fifo_store); // R9

  AST_EVT_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[3:0] == 4'd3 || cfg_rdata[3:0] == 4'd4) |-> !cap_done); // R9

  AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (!trig_pulse && !fifo_store && !cap_done && !evt_store)); // R10
endmodule

bind dbg_trig_ctrl dbg_trig_chk u_chk (.*);

// File: tb/dbg_trig_ctrl_tb.sv
module dbg_trig_ctrl_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic arm = 1'b0, match_a = 1'b0, match_b = 1'b0, acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [AW-1:0] bound_lo = 16'h0100;
  logic [AW-1:0] bound_hi = 16'h0200;
  logic op_exec = 1'b0, op_flush = 1'b0;
  logic trig_pulse, fifo_store, cap_done, evt_store;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dbg_trig_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .arm(arm), .match_a(match_a), .match_b(match_b), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .bound_lo(bound_lo), .bound_hi(bound_hi),
    .op_exec(op_exec), .op_flush(op_flush), .trig_pulse(trig_pulse),
    .fifo_store(fifo_store), .cap_done(cap_done), .evt_store(evt_store)
  );

  // {mode[3:0], a, b, valid, addr[15:0], expected trigger}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1},
    {4'd0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},
    {4'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1},
    {4'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
    {4'd5, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1},
    {4'd5, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},
    {4'd6, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1},
    {4'd6, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0},
    {4'd7, 1'b0, 1'b0, 1'b1, 16'h0100, 1'b1},
    {4'd7, 1'b0, 1'b0, 1'b1, 16'h0201, 1'b0},
    {4'd7, 1'b0, 1'b0, 1'b0, 16'h0150, 1'b0},
    {4'd8, 1'b0, 1'b0, 1'b1, 16'h00FF, 1'b1},
    {4'd8, 1'b0, 1'b0, 1'b1, 16'h0200, 1'b0},
    {4'd9, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0},
    {4'd15, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    match_a = 0; match_b = 0; acc_valid = 0; acc_addr = '0; op_exec = 0; op_flush = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    arm = 0; cfg_we = 1; cfg_wdata = v;
    tick();
    cfg_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R1 reset cfg", cfg_rdata, 8'h00);
    chk("R10 reset outputs", {4'b0, trig_pulse, fifo_store, cap_done, evt_store}, 8'h00);

    // Table walk: combinational, range and reserved modes
    for (int i = 0; i < NV; i++) begin
      quiet();
      wr({4'b0100, VEC[i][23:20]});
      arm = 1;
      match_a = VEC[i][19]; match_b = VEC[i][18]; acc_valid = VEC[i][17];
      acc_addr = VEC[i][16:1];
      tick();
      chk($sformatf("R3/R5 vec %0d mode %0d", i, VEC[i][23:20]),
          {7'b0, trig_pulse}, {7'b0, VEC[i][0]});
      quiet();
      arm = 0;
      tick();
    end

    // R1 layout: reserved bits read 0
    wr(8'hFF);
    chk("R1 write FF", cfg_rdata, 8'hCF);
    // R2 write while armed ignored
    arm = 1; cfg_we = 1; cfg_wdata = 8'h00;
    tick();
    cfg_we = 0;
    chk("R2 armed write", cfg_rdata, 8'hCF);
    arm = 0; tick();

    // R4 A then B
    wr(8'h02); arm = 1;
    match_b = 1; tick(); chk("R4 B alone", {7'b0, trig_pulse}, 8'h00);
    match_b = 0; match_a = 1; tick(); chk("R4 A only", {7'b0, trig_pulse}, 8'h00);
    match_a = 0; tick();
    match_b = 1; tick(); chk("R4 B after A", {7'b0, trig_pulse}, 8'h01);
    match_b = 0; tick(); chk("R10 single pulse", {7'b0, trig_pulse}, 8'h00);
    arm = 0; tick();
    arm = 1; match_a = 1; match_b = 1; tick();
    chk("R4 same cycle", {7'b0, trig_pulse}, 8'h00);
    match_a = 0; tick(); chk("R4 B next cycle", {7'b0, trig_pulse}, 8'h01);
    quiet(); arm = 0; tick();
    // R10 disarm clears sequence flag
    arm = 1; match_a = 1; tick(); match_a = 0;
    arm = 0; tick();
    arm = 1; match_b = 1; tick();
    chk("R10 seq cleared", {7'b0, trig_pulse}, 8'h00);
    quiet(); arm = 0; tick();

    // R7 end trace
    wr(8'h00); arm = 1; tick();
    chk("R7 pre store", {6'b0, fifo_store, cap_done}, 8'h02);
    match_a = 1; tick();
    chk("R7 trigger cycle", {5'b0, trig_pulse, fifo_store, cap_done}, 8'h07);
    match_a = 0; tick();
    chk("R7 after trigger", {5'b0, trig_pulse, fifo_store, cap_done}, 8'h01);
    match_a = 1; tick();
    chk("R10 no retrigger", {7'b0, trig_pulse}, 8'h00);
    match_a = 0; arm = 0; tick();
    chk("R10 disarm outputs", {5'b0, trig_pulse, fifo_store, cap_done}, 8'h00);

    // R8 begin trace
    wr(8'h40); arm = 1; tick();
    chk("R8 pre store", {6'b0, fifo_store, cap_done}, 8'h00);
    match_a = 1; tick();
    chk("R8 trigger", {5'b0, trig_pulse, fifo_store, cap_done}, 8'h06);
    match_a = 0; tick();
    chk("R8 storing", {5'b0, trig_pulse, fifo_store, cap_done}, 8'h02);
    arm = 0; tick();

    // R9 event-only B, begin bit 0 ignored
    wr(8'h03); arm = 1; tick();
    chk("R9 idle no store", {7'b0, fifo_store}, 8'h00);
    match_b = 1; tick();
    chk("R9 first event", {4'b0, trig_pulse, fifo_store, cap_done, evt_store}, 8'h0D);
    tick();
    chk("R9 second event", {4'b0, trig_pulse, fifo_store, cap_done, evt_store}, 8'h05);
    match_b = 0; tick();
    chk("R9 no event", {4'b0, trig_pulse, fifo_store, cap_done, evt_store}, 8'h00);
    arm = 0; tick();
    // R9 A then event B
    wr(8'h04); arm = 1;
    match_b = 1; tick(); chk("R9 B before A", {7'b0, evt_store}, 8'h00);
    match_b = 0; match_a = 1; tick();
    match_a = 0; match_b = 1; tick(); chk("R9 B after A", {7'b0, evt_store}, 8'h01);
    quiet(); arm = 0; tick();

    // R6 tag qualification
    wr(8'h80); arm = 1;
    match_a = 1; tick(); chk("R6 tagged no fire", {7'b0, trig_pulse}, 8'h00);
    match_a = 0; tick(); chk("R6 pending", {7'b0, trig_pulse}, 8'h00);
    op_exec = 1; tick(); chk("R6 executed", {7'b0, trig_pulse}, 8'h01);
    op_exec = 0; arm = 0; tick();
    arm = 1; match_a = 1; tick();
    match_a = 0; op_flush = 1; tick();
    op_flush = 0; op_exec = 1; tick();
    chk("R6 flushed", {7'b0, trig_pulse}, 8'h00);
    quiet(); arm = 0; tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule